// File: doc/BRIEF.md
# Endpoint-0 Control Transfer Stage Sequencer

This block tracks a device's endpoint-0 control transfers through their three phases: setup, an optional data phase, and status. It works from decoded events that a packet layer supplies. These are token pulses (SETUP, IN, OUT), received data bytes with an end-of-packet "good" strobe, and the host's ACK after an IN packet. The block keeps the eight setup bytes in a shadow buffer. When a well-formed setup packet ends, it commits them to four 16-bit request words. It then chooses the next phase from the request's direction bit and its length field. It raises an interrupt flag each time a phase ends, so that firmware can act at that point.

Firmware reads the current phase and the request words through a small word-addressed register port. It arms the zero-length status handshake by setting a completion-enable bit. Until that bit is set, the block answers the status-phase token or packet with NAK. When a new SETUP token arrives, the block drops the enable bit and restarts the sequence, whatever phase it is in.

Top module: `ep0_stage_seq`

## Requirements
- R1: After reset the phase code is 0 (idle), the interrupt flag and completion-enable bit are 0, and all four request words read 0.
- R2: A setup packet of exactly 8 bytes followed by `rx_ok` commits the bytes little-endian. Address 1 reads {byte1, byte0}, address 2 reads {byte3, byte2}, address 3 reads {byte5, byte4} and address 4 reads {byte7, byte6}. Data-phase bytes never alter these words.
- R3: A setup packet whose byte count is not 8 leaves the request words unchanged, returns the phase to idle (0) and does not set the interrupt flag.
- R4: After a committed setup, the phase becomes status-in (4) when bytes 6–7 are both zero. Otherwise it becomes data-in (2) when bit 7 of byte 0 is 1, and data-out (3) when that bit is 0.
- R5: In data-in, an OUT token moves the phase to status-out (5). In data-out, an IN token moves it to status-in (4).
- R6: The interrupt flag (status bit 8, also the `irq` pin) is set in three cases: at setup commit, at the move from data to status, and at transfer completion. Writing 1 to bit 8 of address 0 clears it. A set in the same cycle takes priority over the clear.
- R7: Writing 1 to bit 9 of address 0 sets the completion-enable bit only while the phase is data or status (codes 2–5). In idle or setup the write is ignored.
- R8: A SETUP token clears the completion-enable bit.
- R9: While the completion-enable bit is 0, an IN token in status-in, or a zero-length packet in status-out, produces a one-cycle `hs_nak` in the next cycle and leaves the phase unchanged.
- R10: With the enable bit set, an IN token in status-in produces `zlp_tx` in the next cycle, and a later `ack_rcvd` returns the phase to idle. In status-out, a zero-length `rx_ok` produces `hs_ack` and returns the phase to idle. At most one of `hs_ack`, `hs_nak` and `zlp_tx` is high at a time.
- R11: A SETUP token in any phase moves the phase to setup (1) in the next cycle.
- R12: Address 0 reads the phase code in bits 2:0, the interrupt flag in bit 8 and the completion-enable bit in bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_setup | input | 1 | SETUP token addressed to endpoint 0 (pulse) |
| tok_in | input | 1 | IN token addressed to endpoint 0 (pulse) |
| tok_out | input | 1 | OUT token addressed to endpoint 0 (pulse) |
| rx_vld | input | 1 | One received data byte is valid |
| rx_byte | input | 8 | Received data byte |
| rx_ok | input | 1 | Received data packet ended with good CRC (pulse) |
| ack_rcvd | input | 1 | Host ACK after a device IN packet (pulse) |
| hs_ack | output | 1 | Send ACK for the status packet (pulse) |
| hs_nak | output | 1 | Send NAK for the status token or packet (pulse) |
| zlp_tx | output | 1 | Send a zero-length data packet (pulse) |
| irq | output | 1 | Phase-change interrupt flag |
| cpu_addr | input | 3 | Register word address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational) |

## Verification
The directed tests drive a control read, a control write and a no-data request, with a nonzero index so that a byte-order slip shows up. A byte swap or word shift would show up as request words that read back wrong. If the data-phase bytes were captured, the length word would be overwritten. A truncated setup packet must leave the previous request intact and raise no interrupt. A design that committed it anyway would expose garbage to firmware. The tests try to arm completion while idle and expect the write to be ignored. They probe the status token before arming and expect a NAK without a phase change. They send a fresh SETUP mid-transfer and expect the enable bit to drop and the phase to return to setup.

// File: rtl/ep0_seq_pkg.sv
`timescale 1ns/1ps
package ep0_seq_pkg;

    localparam int SETUP_LEN = 8;
    localparam int WORD_W    = 16;
    localparam int N_WORDS   = SETUP_LEN / 2;
    localparam int CNT_W     = 4;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_REQ    = 3'd1;
    localparam logic [ADDR_W-1:0] A_VAL    = 3'd2;
    localparam logic [ADDR_W-1:0] A_IDX    = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEN    = 3'd4;

    localparam int BIT_IRQ  = 8;
    localparam int BIT_CPLE = 9;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_DIN   = 3'd2,
        ST_DOUT  = 3'd3,
        ST_SIN   = 3'd4,
        ST_SOUT  = 3'd5
    } stage_t;

    typedef struct packed {
        logic ack;
        logic nak;
        logic zlp;
    } hs_t;

    // Phase that follows a committed setup packet.
    function automatic stage_t route_after_setup(input logic dir_in, input logic len_zero);
        if (len_zero)
            return ST_SIN;
        else if (dir_in)
            return ST_DIN;
        else
            return ST_DOUT;
    endfunction

    // Firmware may arm completion only once setup is over.
    function automatic logic arm_allowed(input stage_t s);
        return (s == ST_DIN) || (s == ST_DOUT) || (s == ST_SIN) || (s == ST_SOUT);
    endfunction

endpackage

// File: rtl/ep0_setup_capture.sv
`timescale 1ns/1ps
module ep0_setup_capture
    import ep0_seq_pkg::*;
#(
    parameter int N_BYTES = SETUP_LEN,
    parameter int CW      = CNT_W,
    localparam int NW     = N_BYTES / 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pkt_start,
    input  logic                     capt_en,
    input  logic                     rx_vld,
    input  logic [7:0]               rx_byte,
    input  logic                     commit,
    output logic                     cnt_full,
    output logic                     cnt_zero,
    output logic                     dir_in,
    output logic                     len_zero,
    output logic [NW-1:0][WORD_W-1:0] words
);

    logic [CW-1:0] cnt_q;
    logic [7:0]    sh_q [N_BYTES];

    // Byte counter per packet, saturating
    always_ff @(posedge clk) begin
        if (rst || pkt_start)
            cnt_q <= '0;
        else if (rx_vld && (cnt_q != '1))
            cnt_q <= cnt_q + 1'b1;
    end

    // Shadow buffer, one slot per setup byte
    for (genvar b = 0; b < N_BYTES; b++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst)
                sh_q[b] <= '0;
            else if (rx_vld && capt_en && (cnt_q == CW'(b)))
                sh_q[b] <= rx_byte;
        end
    end

    // Committed request words, little-endian byte pairs
    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [WORD_W-1:0] wq;
        always_ff @(posedge clk) begin
            if (rst)
                wq <= '0;
            else if (commit)
                wq <= {sh_q[2*w+1], sh_q[2*w]};
        end
        assign words[w] = wq;
    end

    assign cnt_full = (cnt_q == CW'(N_BYTES));
    assign cnt_zero = (cnt_q == '0);
    assign dir_in   = sh_q[0][7];
    assign len_zero = ({sh_q[N_BYTES-1], sh_q[N_BYTES-2]} == '0);

endmodule

// File: rtl/ep0_stage_fsm.sv
`timescale 1ns/1ps
module ep0_stage_fsm
    import ep0_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tok_setup,
    input  logic   tok_in,
    input  logic   tok_out,
    input  logic   rx_ok,
    input  logic   ack_rcvd,
    input  logic   cnt_full,
    input  logic   cnt_zero,
    input  logic   dir_in,
    input  logic   len_zero,
    input  logic   arm_req,
    output stage_t stage,
    output logic   cple,
    output logic   commit,
    output logic   stage_evt,
    output hs_t    hs
);

    stage_t stage_q, stage_d;
    logic   cple_q, cple_d;
    logic   zlp_sent_q, zlp_sent_d;
    hs_t    hs_q, hs_d;

    always_comb begin
        stage_d    = stage_q;
        zlp_sent_d = zlp_sent_q;
        hs_d       = '0;
        commit     = 1'b0;
        if (tok_setup) begin
            stage_d    = ST_SETUP;
            zlp_sent_d = 1'b0;
        end else begin
            unique case (stage_q)
                ST_SETUP: begin
                    if (rx_ok) begin
                        if (cnt_full) begin
                            commit  = 1'b1;
                            stage_d = route_after_setup(dir_in, len_zero);
                        end else begin
                            stage_d = ST_IDLE;
                        end
                    end
                end
                ST_DIN: begin
                    if (tok_out)
                        stage_d = ST_SOUT;
                end
                ST_DOUT: begin
                    if (tok_in)
                        stage_d = ST_SIN;
                end
                ST_SIN: begin
                    if (tok_in) begin
                        if (cple_q) begin
                            hs_d.zlp   = 1'b1;
                            zlp_sent_d = 1'b1;
                        end else begin
                            hs_d.nak = 1'b1;
                        end
                    end else if (ack_rcvd && zlp_sent_q) begin
                        stage_d    = ST_IDLE;
                        zlp_sent_d = 1'b0;
                    end
                end
                ST_SOUT: begin
                    if (rx_ok && cnt_zero) begin
                        if (cple_q) begin
                            hs_d.ack = 1'b1;
                            stage_d  = ST_IDLE;
                        end else begin
                            hs_d.nak = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Completion enable: cleared by SETUP, armed only after setup
    always_comb begin
        if (tok_setup)
            cple_d = 1'b0;
        else if (arm_req && arm_allowed(stage_q))
            cple_d = 1'b1;
        else
            cple_d = cple_q;
    end

    assign stage_evt = (stage_d != stage_q) && (stage_d != ST_SETUP) &&
                       !((stage_q == ST_SETUP) && (stage_d == ST_IDLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q    <= ST_IDLE;
            cple_q     <= 1'b0;
            zlp_sent_q <= 1'b0;
            hs_q       <= '0;
        end else begin
            stage_q    <= stage_d;
            cple_q     <= cple_d;
            zlp_sent_q <= zlp_sent_d;
            hs_q       <= hs_d;
        end
    end

    assign stage = stage_q;
    assign cple  = cple_q;
    assign hs    = hs_q;

endmodule

// File: rtl/ep0_cpu_regs.sv
`timescale 1ns/1ps
module ep0_cpu_regs
    import ep0_seq_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  stage_t                        stage,
    input  logic                          cple,
    input  logic                          stage_evt,
    input  logic [N_WORDS-1:0][WORD_W-1:0] words,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic                          cpu_wr,
    input  logic [WORD_W-1:0]             cpu_wdata,
    output logic                          irq,
    output logic                          arm_req,
    output logic [WORD_W-1:0]             cpu_rdata
);

    logic irq_q;
    logic wr_stat;

    assign wr_stat = cpu_wr && (cpu_addr == A_STATUS);
    assign arm_req = wr_stat && cpu_wdata[BIT_CPLE];

    // Set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else if (stage_evt)
            irq_q <= 1'b1;
        else if (wr_stat && cpu_wdata[BIT_IRQ])
            irq_q <= 1'b0;
    end

    assign irq = irq_q;

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            A_STATUS: begin
                cpu_rdata[2:0]      = stage;
                cpu_rdata[BIT_IRQ]  = irq_q;
                cpu_rdata[BIT_CPLE] = cple;
            end
            A_REQ:   cpu_rdata = words[0];
            A_VAL:   cpu_rdata = words[1];
            A_IDX:   cpu_rdata = words[2];
            A_LEN:   cpu_rdata = words[3];
            default: cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ep0_stage_seq.sv
`timescale 1ns/1ps
module ep0_stage_seq
    import ep0_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tok_setup,
    input  logic        tok_in,
    input  logic        tok_out,
    input  logic        rx_vld,
    input  logic [7:0]  rx_byte,
    input  logic        rx_ok,
    input  logic        ack_rcvd,
    output logic        hs_ack,
    output logic        hs_nak,
    output logic        zlp_tx,
    output logic        irq,
    input  logic [2:0]  cpu_addr,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata
);

    stage_t stage_q;
    logic   cple_q;
    logic   commit, stage_evt, arm_req;
    logic   cnt_full, cnt_zero, dir_in, len_zero;
    hs_t    hs;
    logic [N_WORDS-1:0][WORD_W-1:0] words;

    ep0_setup_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .pkt_start (tok_setup | tok_out),
        .capt_en   (stage_q == ST_SETUP),
        .rx_vld    (rx_vld),
        .rx_byte   (rx_byte),
        .commit    (commit),
        .cnt_full  (cnt_full),
        .cnt_zero  (cnt_zero),
        .dir_in    (dir_in),
        .len_zero  (len_zero),
        .words     (words)
    );

    ep0_stage_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tok_setup (tok_setup),
        .tok_in    (tok_in),
        .tok_out   (tok_out),
        .rx_ok     (rx_ok),
        .ack_rcvd  (ack_rcvd),
        .cnt_full  (cnt_full),
        .cnt_zero  (cnt_zero),
        .dir_in    (dir_in),
        .len_zero  (len_zero),
        .arm_req   (arm_req),
        .stage     (stage_q),
        .cple      (cple_q),
        .commit    (commit),
        .stage_evt (stage_evt),
        .hs        (hs)
    );

    ep0_cpu_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .stage     (stage_q),
        .cple      (cple_q),
        .stage_evt (stage_evt),
        .words     (words),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .irq       (irq),
        .arm_req   (arm_req),
        .cpu_rdata (cpu_rdata)
    );

    assign hs_ack = hs.ack;
    assign hs_nak = hs.nak;
    assign zlp_tx = hs.zlp;

endmodule

// File: rtl/ep0_stage_seq_chk.sv
`timescale 1ns/1ps
module ep0_stage_seq_chk
    import ep0_seq_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   tok_setup,
    input logic   tok_in,
    input stage_t stage,
    input logic   cple,
    input logic   irq,
    input logic   hs_ack,
    input logic   hs_nak,
    input logic   zlp_tx
);

    // R11
    setup_abort_chk: assert property (@(posedge clk) disable iff (rst)
        tok_setup |=> (stage == ST_SETUP));

    // R8
    cple_clear_chk: assert property (@(posedge clk) disable iff (rst)
        tok_setup |=> !cple);

    // R7
    cple_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cple) |-> ($past(stage) != ST_IDLE && $past(stage) != ST_SETUP));

    // R9
    status_nak_chk: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_SIN && !cple && tok_in && !tok_setup) |=> (hs_nak && stage == ST_SIN));

    // R10
    ack_done_chk: assert property (@(posedge clk) disable iff (rst)
        hs_ack |-> (stage == ST_IDLE));

    // R10
    hs_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hs_ack, hs_nak, zlp_tx}));

    // R6
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_IDLE && ($past(stage) == ST_SIN || $past(stage) == ST_SOUT)) |-> irq);

endmodule

bind ep0_stage_seq ep0_stage_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tok_setup (tok_setup),
    .tok_in    (tok_in),
    .stage     (stage_q),
    .cple      (cple_q),
    .irq       (irq),
    .hs_ack    (hs_ack),
    .hs_nak    (hs_nak),
    .zlp_tx    (zlp_tx)
);

// File: tb/sim_ep0_stage_seq.sv
`timescale 1ns/1ps
module sim_ep0_stage_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tok_setup = 0, tok_in = 0, tok_out = 0;
    logic        rx_vld = 0, rx_ok = 0, ack_rcvd = 0;
    logic [7:0]  rx_byte = '0;
    logic        hs_ack, hs_nak, zlp_tx, irq;
    logic [2:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ep0_stage_seq u0 (
        .clk(clk), .rst(rst),
        .tok_setup(tok_setup), .tok_in(tok_in), .tok_out(tok_out),
        .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_ok(rx_ok), .ack_rcvd(ack_rcvd),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .zlp_tx(zlp_tx), .irq(irq),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // event codes: 0 setup, 1 in, 2 out, 3 rx_ok, 4 ack
    task automatic ev(input int k);
        @(negedge clk);
        case (k)
            0: tok_setup = 1'b1;
            1: tok_in    = 1'b1;
            2: tok_out   = 1'b1;
            3: rx_ok     = 1'b1;
            default: ack_rcvd = 1'b1;
        endcase
        @(negedge clk);
        tok_setup = 0; tok_in = 0; tok_out = 0; rx_ok = 0; ack_rcvd = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_vld = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_vld = 1'b0;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        cpu_addr = a;
        #0.5;
        d = cpu_rdata;
    endtask

    task automatic send_setup(input logic [63:0] pkt, input int nbytes);
        ev(0);
        for (int i = 0; i < nbytes; i++) send_byte(pkt[8*i +: 8]);
        ev(3);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        reg_rd(3'd0, d); check("R1 status", d, 16'h0000);
        check("R1 irq pin", {15'd0, irq}, 16'h0000);
        for (int a = 1; a <= 4; a++) begin
            reg_rd(3'(a), d); check("R1 request word", d, 16'h0000);
        end
        // R7: arming while idle is ignored
        reg_wr(3'd0, 16'h0200);
        reg_rd(3'd0, d); check("R7 arm in idle ignored", d, 16'h0000);
    endtask

    task automatic t_ctrl_read();
        logic [15:0] d;
        // bytes 0..7: 80 06 00 01 34 12 12 00
        send_setup(64'h0012_1234_0100_0680, 8);
        reg_rd(3'd0, d); check("R4 R6 R12 data-in with irq", d, 16'h0102);
        reg_rd(3'd1, d); check("R2 request word", d, 16'h0680);
        reg_rd(3'd2, d); check("R2 value word", d, 16'h0100);
        reg_rd(3'd3, d); check("R2 index word", d, 16'h1234);
        reg_rd(3'd4, d); check("R2 length word", d, 16'h0012);
        reg_wr(3'd0, 16'h0100);
        check("R6 irq cleared", {15'd0, irq}, 16'h0000);
        ev(2);
        reg_rd(3'd0, d); check("R5 data-in to status-out", d, 16'h0105);
        reg_wr(3'd0, 16'h0100);
        ev(2);
        ev(3);
        check("R9 nak status-out", {15'd0, hs_nak}, 16'h0001);
        reg_rd(3'd0, d); check("R9 stage held", d, 16'h0005);
        reg_wr(3'd0, 16'h0200);
        reg_rd(3'd0, d); check("R7 arm in status", d, 16'h0205);
        ev(2);
        ev(3);
        check("R10 ack status-out", {15'd0, hs_ack}, 16'h0001);
        reg_rd(3'd0, d); check("R10 R6 done to idle", d, 16'h0300);
        reg_wr(3'd0, 16'h0100);
    endtask

    task automatic t_ctrl_write();
        logic [15:0] d;
        // bytes: 21 09 00 02 00 00 04 00
        send_setup(64'h0004_0000_0200_0921, 8);
        reg_rd(3'd0, d); check("R4 R8 data-out, enable cleared", d, 16'h0103);
        reg_wr(3'd0, 16'h0100);
        ev(2);
        send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC); send_byte(8'hDD);
        ev(3);
        reg_rd(3'd0, d); check("R2 data phase keeps stage", d, 16'h0003);
        reg_rd(3'd1, d); check("R2 data bytes ignored req", d, 16'h0921);
        reg_rd(3'd4, d); check("R2 data bytes ignored len", d, 16'h0004);
        ev(1);
        reg_rd(3'd0, d); check("R5 data-out to status-in", d, 16'h0104);
        reg_wr(3'd0, 16'h0100);
        ev(1);
        check("R9 nak status-in", {15'd0, hs_nak}, 16'h0001);
        check("R9 no zlp before arm", {15'd0, zlp_tx}, 16'h0000);
        reg_wr(3'd0, 16'h0200);
        ev(1);
        check("R10 zlp sent", {15'd0, zlp_tx}, 16'h0001);
        reg_rd(3'd0, d); check("R10 still status-in", d, 16'h0204);
        ev(4);
        reg_rd(3'd0, d); check("R10 R6 ack completes", d, 16'h0300);
        reg_wr(3'd0, 16'h0100);
    endtask

    task automatic t_no_data();
        logic [15:0] d;
        // bytes: 00 05 07 00 00 00 00 00
        send_setup(64'h0000_0000_0007_0500, 8);
        reg_rd(3'd0, d); check("R4 zero length to status-in", d, 16'h0104);
        reg_rd(3'd2, d); check("R2 value word", d, 16'h0007);
        reg_wr(3'd0, 16'h0100);
    endtask

    task automatic t_short_setup();
        logic [15:0] d;
        ev(0);
        for (int i = 0; i < 5; i++) send_byte(8'hF0 + 8'(i));
        ev(3);
        reg_rd(3'd0, d); check("R3 short setup back to idle, no irq", d, 16'h0000);
        reg_rd(3'd1, d); check("R3 request kept", d, 16'h0500);
        reg_rd(3'd2, d); check("R3 value kept", d, 16'h0007);
    endtask

    task automatic t_abort();
        logic [15:0] d;
        send_setup(64'h0040_0000_0000_0680, 8);
        reg_wr(3'd0, 16'h0300);
        reg_rd(3'd0, d); check("R7 armed in data-in", d, 16'h0202);
        ev(0);
        reg_rd(3'd0, d); check("R11 R8 abort to setup", d, 16'h0001);
        send_setup(64'h0000_0000_0001_0300, 8);
        reg_rd(3'd0, d); check("R4 restarted transfer", d, 16'h0104);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_read();
        t_ctrl_write();
        t_no_data();
        t_short_setup();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule